// File: doc/BRIEF.md
# Serial Pad Configuration Link

This block is one stage of a serial chain that runs past every I/O pad of a chip. Each stage has a shift register as wide as one pad control word and a holding register that drives the pad's local control lines. A serial source at the head of the chain sends every pad's word in turn. On each rising edge of the serial clock every stage shifts one place, and the most significant bit of each stage passes to the next one.

There is no separate load pin. The same active-low line carries both the strobe and the clear, and the serial clock level tells them apart. If the line falls while the serial clock is high, every stage copies its shift register into its holding register. If the line is low while the serial clock is low, both registers are cleared at once. The source changes data only while the clock is low. It sends words most significant bit first, starting with the word for the pad farthest down the chain. The last rising edge of a transfer is the one that opens the load sequence: the clock rises, the line pulses low and returns high while the clock stays high, and then the clock falls.

Top module: `padcfg_link`

## Requirements
- R1: On each rising edge of `sclk` while the shift register is not being cleared, the shift register moves one place toward its MSB and `sdi` enters bit 0. A bit therefore appears on `sdo` on the 14th rising edge after it was presented, and not before.
- R2: `sdo` is the MSB of the shift register. It changes only as a result of a rising edge of `sclk` or a clear.
- R3: In a chain of N stages, after N×14 rising edges (the last one belonging to the load sequence) and one load strobe, stage k holds the word that was sent as the (N−k)-th word, counting from 1 and from the head of the chain.
- R4: A falling edge of `sline_n` while `sclk` is high copies the shift register into `cfg_word`. The shift register is left unchanged, so the next rising edge of `sclk` puts the old bit 12 on `sdo`.
- R5: `cfg_word` does not change on shift edges. It changes only on a load strobe or a clear.
- R6: While `sline_n` and `sclk` are both low, the shift register and `cfg_word` are cleared to zero at once, without a clock edge, and `sdo` is 0.
- R7: `cfg_oe_n` is bit 1 of the latched word. A value of 0 means the management output value drives the pad. A value of 1 means the pad is an input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock. Data is sampled on its rising edge. |
| sline_n | input | 1 | Active-low strobe/clear line. It loads when `sclk` is high and clears when `sclk` is low. |
| sdi | input | 1 | Serial data from the previous stage or from the source. |
| sdo | output | 1 | Serial data to the next stage (MSB of the shift register). |
| cfg_word | output | 14 | Latched pad control word. |
| cfg_oe_n | output | 1 | Output-enable-bar, taken from bit 1 of the latched word. |

## Verification
On every change of their inputs, the assertions check four things. The latched word changes only during a strobe or a clear. `sdo` rises only on a shift edge. At the end of a strobe, the latched word equals the shift register. A rising clock that arrives while the line is low finds a cleared register. Only the bench's chained scenarios can show the rest: where each word ends up after a full transfer, the 14-edge delay through a stage, that the shift register keeps its contents across a load, and that the clear acts at once with no clock edge.

// File: rtl/padcfg_pkg.sv
package padcfg_pkg;
  // Width of one pad control word and position of its output-enable-bar bit
  localparam int unsigned PAD_CFG_W   = 14;
  localparam int unsigned PAD_OEB_BIT = 1;
endpackage

// File: rtl/padcfg_shreg.sv
module padcfg_shreg #(
  parameter int unsigned W = padcfg_pkg::PAD_CFG_W
) (
  input  logic         sclk,
  input  logic         clr_n,
  input  logic         sline_n,
  input  logic         sdi,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;

  // next state: shift toward MSB, new bit at LSB
  always_comb begin
    q_nxt = {q[W-2:0], sdi};
  end

  always_ff @(posedge sclk or negedge clr_n) begin
    if (!clr_n) begin
      q <= '0;
    end else begin
      q <= q_nxt;
    end
  end

  // R6: a rising clock arriving while the line is low finds the register cleared
  always @(posedge sclk) begin
    if (!sline_n) begin
      a_r6_cleared_before_rise: assert (q == '0)
        else $error("shift register not cleared before rise");
    end
  end

  // R2: the serial output can only rise on a shift edge
  always @(posedge q[W-1]) begin
    a_r2_sdo_rise_on_shift: assert (clr_n && sclk)
      else $error("serial output rose outside a shift edge");
  end
endmodule

// File: rtl/padcfg_hold.sv
module padcfg_hold #(
  parameter int unsigned W = padcfg_pkg::PAD_CFG_W
) (
  input  logic         ld_clk_n,
  input  logic         ld_en,
  input  logic         clr_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;

  // copy only when the strobe falls with the serial clock high
  always_comb begin
    q_nxt = ld_en ? d : q;
  end

  always_ff @(negedge ld_clk_n or negedge clr_n) begin
    if (!clr_n) begin
      q <= '0;
    end else begin
      q <= q_nxt;
    end
  end

  // R5: latched word moves only under clear or a strobe with clock high
  always @(q) begin
    a_r5_latch_quiet: assert (!clr_n || (ld_en && !ld_clk_n))
      else $error("latched word changed outside strobe or clear");
  end
endmodule

// File: rtl/padcfg_decode.sv
module padcfg_decode #(
  parameter int unsigned W       = padcfg_pkg::PAD_CFG_W,
  parameter int unsigned OEB_BIT = padcfg_pkg::PAD_OEB_BIT
) (
  input  logic [W-1:0] word,
  output logic         oe_n
);
  // output-enable-bar field of the control word
  always_comb begin
    oe_n = word[OEB_BIT];
  end
endmodule

// File: rtl/padcfg_link.sv
module padcfg_link #(
  parameter int unsigned CFG_W   = padcfg_pkg::PAD_CFG_W,
  parameter int unsigned OEB_BIT = padcfg_pkg::PAD_OEB_BIT
) (
  input  logic             sclk,
  input  logic             sline_n,
  input  logic             sdi,
  output logic             sdo,
  output logic [CFG_W-1:0] cfg_word,
  output logic             cfg_oe_n
);
  logic             clr_n;
  logic [CFG_W-1:0] sh_q;

  // the line low with the clock low is a clear; with the clock high it is a strobe
  assign clr_n = sline_n | sclk;

  padcfg_shreg #(.W(CFG_W)) u_shreg (
    .sclk    (sclk),
    .clr_n   (clr_n),
    .sline_n (sline_n),
    .sdi     (sdi),
    .q       (sh_q)
  );

  padcfg_hold #(.W(CFG_W)) u_hold (
    .ld_clk_n (sline_n),
    .ld_en    (sclk),
    .clr_n    (clr_n),
    .d        (sh_q),
    .q        (cfg_word)
  );

  padcfg_decode #(.W(CFG_W), .OEB_BIT(OEB_BIT)) u_decode (
    .word (cfg_word),
    .oe_n (cfg_oe_n)
  );

  assign sdo = sh_q[CFG_W-1];

  // R4: at the end of a strobe, the latched word equals the retained shift contents
  always @(posedge sline_n) begin
    if (sclk) begin
      a_r4_load_copy: assert (cfg_word == sh_q)
        else $error("latched word differs from shift register after strobe");
    end
  end
endmodule

// File: tb/padcfg_link_tb.sv
module padcfg_link_tb;
  import padcfg_pkg::*;

  localparam int NL = 4;
  localparam int W  = PAD_CFG_W;
  localparam int NB = NL * W;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          sclk;
  logic          sline_n;
  logic          sdata;
  logic [NL:0]   sd;
  logic [W-1:0]  cfg [NL];
  logic [NL-1:0] oen;
  logic [W-1:0]  wv  [NL];
  logic [W-1:0]  prev[NL];

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  assign sd[0] = sdata;

  padcfg_link u_dut (
    .sclk(sclk), .sline_n(sline_n), .sdi(sd[0]), .sdo(sd[1]),
    .cfg_word(cfg[0]), .cfg_oe_n(oen[0])
  );

  for (genvar k = 1; k < NL; k++) begin : g_link
    padcfg_link u_link (
      .sclk(sclk), .sline_n(sline_n), .sdi(sd[k]), .sdo(sd[k+1]),
      .cfg_word(cfg[k]), .cfg_oe_n(oen[k])
    );
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // stream bit j: farthest pad's word first, MSB first
  function automatic logic sbit(input int j);
    return wv[NL-1-(j/W)][W-1-(j%W)];
  endfunction

  task automatic push_bit(input logic b, input bit ld);
    @(negedge clk) sdata = b;
    @(negedge clk) sclk = 1'b1;
    if (ld) begin
      @(negedge clk) sline_n = 1'b0;
      @(negedge clk) sline_n = 1'b1;
    end
    @(negedge clk) sclk = 1'b0;
    @(negedge clk);
  endtask

  task automatic send_range(input int from, input int to, input bit ld_last);
    for (int j = from; j <= to; j++) push_bit(sbit(j), ld_last && (j == NB-1));
  endtask

  task automatic check_all(input string tag);
    for (int k = 0; k < NL; k++) begin
      chk(tag, 32'(cfg[k]), 32'(wv[k]));
      chk({tag, " R7 oe_n"}, 32'(oen[k]), 32'(wv[k][PAD_OEB_BIT]));
    end
  endtask

  task automatic t_reset;
    sclk = 1'b0; sline_n = 1'b0; sdata = 1'b0;
    repeat (3) @(negedge clk);
    for (int k = 0; k < NL; k++) chk("R6 reset cfg", 32'(cfg[k]), 0);
    chk("R6 reset sdo", 32'(sd[NL]), 0);
    sline_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_load(input logic [W-1:0] a0, a1, a2, a3);
    wv[0] = a0; wv[1] = a1; wv[2] = a2; wv[3] = a3;
    send_range(0, NB-1, 1'b1);
    check_all("R3 load");
    chk("R2 sdo msb of last stage", 32'(sd[NL]), 32'(wv[NL-1][W-1]));
  endtask

  task automatic t_shift_quiet(input logic [W-1:0] a0, a1, a2, a3);
    for (int k = 0; k < NL; k++) prev[k] = wv[k];
    wv[0] = a0; wv[1] = a1; wv[2] = a2; wv[3] = a3;
    send_range(0, NB/2-1, 1'b0);
    for (int k = 0; k < NL; k++) chk("R5 mid shift", 32'(cfg[k]), 32'(prev[k]));
    send_range(NB/2, NB-2, 1'b0);
    for (int k = 0; k < NL; k++) chk("R5 before load", 32'(cfg[k]), 32'(prev[k]));
    send_range(NB-1, NB-1, 1'b1);
    check_all("R3 R4 load after shift");
    // one more shift: the retained shift contents move on, latch stays
    push_bit(1'b0, 1'b0);
    chk("R4 shift kept", 32'(sd[NL]), 32'(wv[NL-1][W-2]));
    check_all("R5 after extra shift");
  endtask

  task automatic t_clear_async;
    @(negedge clk) sline_n = 1'b0;
    #2;
    for (int k = 0; k < NL; k++) chk("R6 async clear", 32'(cfg[k]), 0);
    chk("R6 async clear sdo", 32'(sd[NL]), 0);
    @(negedge clk) sline_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_delay;
    push_bit(1'b1, 1'b0);
    for (int j = 1; j < W-1; j++) push_bit(1'b0, 1'b0);
    chk("R1 not yet out", 32'(sd[1]), 0);
    push_bit(1'b0, 1'b0);
    chk("R1 out after 14 edges", 32'(sd[1]), 1);
    chk("R2 next stage not yet", 32'(sd[2]), 0);
    chk("R5 no load cfg0", 32'(cfg[0]), 0);
  endtask

  initial begin
    t_reset();
    t_load(14'h3FFF, 14'h0002, 14'h2AA8, 14'h1555);
    t_shift_quiet(14'h1A5B, 14'h0F0F, 14'h2D4C, 14'h0000);
    t_clear_async();
    t_delay();
    t_clear_async();
    t_load(14'h0001, 14'h2000, 14'h0003, 14'h3FFD);
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000 && !done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below 200000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule